// File: doc/BRIEF.md
# OTG Line Status Tracker

This block keeps the 16-bit OTG status word that software reads back. Two level inputs arrive from the USB core: one reports that VBUS is valid, the other reports that a session is valid. On every clock the block registers both levels into the status word. The block also compares the incoming VBUS level with the bit it already holds, and it emits a one-cycle VBUS-change pulse only when the two differ. The session input drives a pair of flags that are always opposite to each other, and it never raises an event.

The status word is a plain registered output that can be read at any time; it has no handshake. The event output is a plain pulse that the surrounding interrupt logic latches into its own source bit. Debounce timers, PHY control and ID-pin detection are handled elsewhere. Here the ID bit, the line-state pair, the VBUS-sense bit, the host-disconnect bit and the power/clock-good bit all read as zero. An ID bit of zero means host mode.

Top module: `otg_line_status`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, `status_o` reads 0x0000 and `vbus_chg_o` is low.
- R2: Status bit 5 (VBUS valid) equals the level of `vbus_lvl_i` sampled at the previous rising clock edge.
- R3: When `vbus_lvl_i` at a rising edge differs from the stored bit 5, `vbus_chg_o` is high for exactly the following clock cycle. Bit 5 starts at 0 after reset, so the comparison begins from 0.
- R4: While `vbus_lvl_i` holds the level already stored in bit 5, `vbus_chg_o` stays low, however long the level is held.
- R5: A high `sess_lvl_i` sampled at a rising edge sets status bit 6 (session valid) and clears bit 7 (session end).
- R6: A low `sess_lvl_i` sampled at a rising edge sets bit 7 and clears bit 6. From the first edge after reset, bits 6 and 7 therefore always differ.
- R7: A change on `sess_lvl_i` never produces a pulse on `vbus_chg_o`.
- R8: Bits 15:9, bit 8 (power/clock good), bit 4 (VBUS sense), bit 3 (ID status, 0 = host), bit 2 (host disconnect) and bits 1:0 (line state) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_lvl_i | input | 1 | VBUS-valid level from the USB core |
| sess_lvl_i | input | 1 | Session-valid level from the USB core |
| status_o | output | 16 | OTG status word |
| vbus_chg_o | output | 1 | One-cycle pulse on a change of the VBUS-valid bit |

## Verification
A wrong stored VBUS bit shows up at once in bit 5 of the status word. It also shows up in the pulse: a pulse goes missing or an extra one appears on the cycle after the input next moves, because the comparison uses that stored bit. A session flag that is out of step appears as bits 6 and 7 equal on the cycle after the edge, and any leak between the session path and the event path appears as a pulse with bit 5 unchanged. The bench runs a reference model alongside the design and compares every output field on each cycle, so any such divergence is reported within one clock of its cause.

// File: rtl/otgsts_pkg.sv
package otgsts_pkg;
  localparam int unsigned STAT_W      = 16;
  localparam int unsigned POS_SES_END = 7;
  localparam int unsigned POS_SES_VLD = 6;
  localparam int unsigned POS_VB_VLD  = 5;
  localparam logic [STAT_W-1:0] LIVE_MASK =
    (STAT_W'(1) << POS_SES_END) | (STAT_W'(1) << POS_SES_VLD) | (STAT_W'(1) << POS_VB_VLD);

  typedef struct packed {
    logic ses_end;
    logic ses_vld;
    logic vb_vld;
  } live_bits_t;
endpackage

// File: rtl/otgsts_vbus_track.sv
module otgsts_vbus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic vld_o,
  output logic chg_o
);
  logic held_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= lvl_i ^ held_q;
      held_q  <= lvl_i;
    end
  end

  assign vld_o = held_q;
  assign chg_o = pulse_q;
endmodule

// File: rtl/otgsts_sess_track.sv
module otgsts_sess_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic vld_o,
  output logic end_o
);
  logic [1:0] pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pair_q <= 2'b00;
    else        pair_q <= lvl_i ? 2'b01 : 2'b10;
  end

  assign vld_o = pair_q[0];
  assign end_o = pair_q[1];
endmodule

// File: rtl/otgsts_word_pack.sv
module otgsts_word_pack
  import otgsts_pkg::*;
(
  input  live_bits_t        live_i,
  output logic [STAT_W-1:0] word_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == POS_SES_END) begin : g_end
      assign word_o[b] = live_i.ses_end;
    end else if (b == POS_SES_VLD) begin : g_vld
      assign word_o[b] = live_i.ses_vld;
    end else if (b == POS_VB_VLD) begin : g_vb
      assign word_o[b] = live_i.vb_vld;
    end else begin : g_zero
      assign word_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/otg_line_status.sv
module otg_line_status
  import otgsts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbus_lvl_i,
  input  logic              sess_lvl_i,
  output logic [STAT_W-1:0] status_o,
  output logic              vbus_chg_o
);
  live_bits_t live;

  otgsts_vbus_track u_vbus (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (vbus_lvl_i),
    .vld_o (live.vb_vld),
    .chg_o (vbus_chg_o)
  );

  otgsts_sess_track u_sess (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (sess_lvl_i),
    .vld_o (live.ses_vld),
    .end_o (live.ses_end)
  );

  otgsts_word_pack u_pack (
    .live_i (live),
    .word_o (status_o)
  );
endmodule

// File: rtl/otg_line_status_chk.sv
module otg_line_status_chk
  import otgsts_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              vbus_lvl_i,
  input logic              sess_lvl_i,
  input logic [STAT_W-1:0] status_o,
  input logic              vbus_chg_o
);
  AST_VBUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_o[POS_VB_VLD] == $past(vbus_lvl_i))); // R2
  AST_CHG_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (status_o[POS_VB_VLD] != $past(status_o[POS_VB_VLD]))) |-> vbus_chg_o); // R3
  AST_NO_CHG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (status_o[POS_VB_VLD] == $past(status_o[POS_VB_VLD]))) |-> !vbus_chg_o); // R4
  AST_SESS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_o[POS_SES_VLD] == $past(sess_lvl_i))); // R5
  AST_SESS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_o[POS_SES_VLD] != status_o[POS_SES_END])); // R6
  AST_SESS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(vbus_lvl_i) && (status_o[POS_VB_VLD] == vbus_lvl_i)) |=> !vbus_chg_o); // R7
  AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~LIVE_MASK) == '0); // R8
endmodule

bind otg_line_status otg_line_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vbus_lvl_i (vbus_lvl_i),
  .sess_lvl_i (sess_lvl_i),
  .status_o   (status_o),
  .vbus_chg_o (vbus_chg_o)
);

// File: tb/tb_otg_line_status.sv
module tb_otg_line_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vbus = 1'b0;
  logic        sess = 1'b0;
  logic [15:0] status;
  logic        chg;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // reference model state
  bit m_vb, m_sv, m_se, m_chg;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  otg_line_status dut (
    .clk(clk), .rst_n(rst_n), .vbus_lvl_i(vbus), .sess_lvl_i(sess),
    .status_o(status), .vbus_chg_o(chg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_vb = 0; m_sv = 0; m_se = 0; m_chg = 0;
    end else begin
      m_chg = (vbus != m_vb);
      m_vb  = vbus;
      m_sv  = sess;
      m_se  = !sess;
    end
  end

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(status[5] == m_vb, "R2", status[5], m_vb);
      check(chg == m_chg, m_chg ? "R3" : "R4", chg, m_chg);
      check(status[6] == m_sv, "R5", status[6], m_sv);
      check(status[7] == m_se, "R6", status[7], m_se);
      check((status & 16'hFF1F) == 16'h0, "R8", status, 0);
    end
  end

  task automatic step(input bit v, input bit s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vbus = v; sess = s;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status == 16'h0, "R1", status, 0);
    check(chg == 1'b0, "R1", chg, 0);
    vbus = 1; sess = 1;
    @(negedge clk);
    rst_n = 1;
    check(status == 16'h0, "R1", status, 0);
    cmp_on = 1;
    // first edge: vbus 1 vs stored 0 gives a pulse
    @(negedge clk);
    check(chg == 1'b1 && status == 16'h0060, "R3", {chg, status}, 17'h10060);
    @(negedge clk);
    check(chg == 1'b0, "R4", chg, 0);
    // hold vbus high for a long stretch
    step(1, 1, 20);
    // R7: toggle session only, vbus steady
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sess = ~sess;
      @(negedge clk);
      check(chg == 1'b0, "R7", chg, 0);
    end
    // vbus falls: a single pulse
    @(negedge clk); vbus = 0;
    @(negedge clk);
    check(chg == 1'b1 && status[5] == 1'b0, "R3", {chg, status[5]}, 2'b10);
    @(negedge clk);
    check(chg == 1'b0, "R3", chg, 0);
    // fast toggling of vbus every cycle
    for (int k = 0; k < 10; k++) step(k[0], k[1], 1);
    // mixed pattern
    for (int k = 0; k < 200; k++) step(((k * 7) % 5) < 2, ((k * 3) % 4) == 1, 1);
    // reset in the middle of activity
    @(negedge clk);
    cmp_on = 0;
    rst_n = 0;
    #1;
    check(status == 16'h0 && chg == 1'b0, "R1", {chg, status}, 0);
    vbus = 0; sess = 0;
    @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    check(status == 16'h0080 && chg == 1'b0, "R6", {chg, status}, 16'h0080);
    step(0, 0, 10);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule